// File: doc/BRIEF.md
# Programmable Bidirectional Parallel Port

An eight-pin general-purpose port that sits between a processor bus and an external device. Software sets each pin, one bit at a time, as an input or an output by writing a direction register. It drives output values from an output-data register and reads back a mix of driven values and synchronized live pin levels. The pad three-state buffers are outside the block: the port supplies separate drive-value, drive-enable and sampled-input vectors.

A chip-select input, three register-select lines, a read/write line and a request/accept handshake reach the internal registers. Each assertion of the request while the port is selected causes exactly one register access. The accept line answers that access and holds until the request is withdrawn. On the device side, an input strobe with programmable edge polarity captures the input pins into a holding register and sets a ready flag. The ready flag can raise an interrupt. An output strobe pulses once for every write to the output-data register.

Top module: `bport`

## Requirements
- R1: After synchronous reset, `pin_oe`, `pin_out`, `irq`, `ack` and `dev_stb_out` are all zero, and all pins are inputs.
- R2: An access occurs only in a cycle where `cs` and `req` are both high and `ack` is low. `ack` rises the cycle after and stays high while `cs` and `req` stay high, so a held request makes only one access. `ack` falls the cycle after `req` drops. Read data is valid on `rdata` while `ack` is high.
- R3: A write to select 1 (direction) loads `pin_oe`. A bit value of 1 makes that pin an output. Reading select 1 returns the same pattern.
- R4: A read of select 0 returns, per bit, the output-data bit where the direction bit is 1. Where the direction bit is 0, it returns the input pin level after two synchronizing flops.
- R5: A write to select 0 loads `pin_out`. A request made while `cs` is low changes no register.
- R6: `dev_stb_out` is high for exactly one cycle, the cycle after each write access to select 0, and at no other time.
- R7: Select 2 (control) holds bit 0 = interrupt enable and bit 1 = strobe polarity (0: rising edge of `dev_stb_in` is active, 1: falling edge). An active edge of the synchronized `dev_stb_in` captures the synchronized pins into the holding register, which reads at select 4, and sets status bit 0 (ready). The status register reads at select 3.
- R8: `irq` equals interrupt enable AND ready. A read access of select 4 clears ready and overrun, unless an active edge is captured in the same cycle.
- R9: An active edge while ready is already set sets status bit 1 (overrun) and overwrites the holding register with the newer sample.
- R10: Selects 5, 6 and 7 read as zero. Writes to them, and to selects 3 and 4, change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Port selected by the external address decoder |
| req | input | 1 | Bus request (master ready) |
| rnw | input | 1 | 1 = read, 0 = write |
| rsel | input | 3 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `ack` is high |
| ack | output | 1 | Bus accept (slave ready) |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad drive enables, 1 = output |
| dev_stb_in | input | 1 | Device input strobe |
| dev_stb_out | output | 1 | Device output strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the cycle-level rules on every clock. These are: `ack` falls after the request is withdrawn, the output strobe lasts one cycle and follows only a data write, and the direction and output-data registers stay unchanged unless a matching write access occurred. Only the bench scenarios can show the data path. That covers the per-bit mix on data reads over random direction patterns, capture on the selected strobe edge after the synchronizer delay, overrun, clearing of ready on a holding-register read, and the inert unused selects.

// File: rtl/bport_pkg.sv
package bport_pkg;

    localparam int PORT_W  = 8;
    localparam int SEL_W   = 3;
    localparam int SYNC_N  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA  = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_STAT  = 3'd3,
        SEL_HOLD  = 3'd4
    } sel_e;

    typedef struct packed {
        logic              fire;
        logic              write;
        logic [SEL_W-1:0]  sel;
        logic [PORT_W-1:0] data;
    } bus_op_t;

    typedef struct packed {
        logic ien;
        logic fall;
    } ctrl_t;

    function automatic logic [PORT_W-1:0] mix_read(
        input logic [PORT_W-1:0] drv,
        input logic [PORT_W-1:0] dir,
        input logic [PORT_W-1:0] live
    );
        return (drv & dir) | (live & ~dir);
    endfunction

endpackage

// File: rtl/bport_sync.sv
module bport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bport_capture.sv
module bport_capture
    import bport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_sync,
    input  logic              fall_sel,
    input  logic [PORT_W-1:0] pins_sync,
    input  logic              clear,
    output logic [PORT_W-1:0] hold,
    output logic              ready,
    output logic              overrun
);
    logic prev;
    logic hit;

    always_comb begin
        if (fall_sel) hit = prev & ~stb_sync;
        else          hit = stb_sync & ~prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= 1'b0;
            hold    <= '0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            prev <= stb_sync;
            if (hit) begin
                hold  <= pins_sync;
                ready <= 1'b1;
                if (ready && !clear) overrun <= 1'b1;
            end else if (clear) begin
                ready   <= 1'b0;
                overrun <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bport_regs.sv
module bport_regs
    import bport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              req,
    input  logic              rnw,
    input  logic [SEL_W-1:0]  rsel,
    input  logic [PORT_W-1:0] wdata,
    input  logic [PORT_W-1:0] pins_sync,
    input  logic [PORT_W-1:0] hold,
    input  logic              ready,
    input  logic              overrun,
    output logic              ack,
    output logic [PORT_W-1:0] rdata,
    output logic [PORT_W-1:0] drv,
    output logic [PORT_W-1:0] dir,
    output ctrl_t             ctrl,
    output logic              stb_out,
    output logic              hold_clear
);
    bus_op_t op;
    logic [PORT_W-1:0] rmux;

    always_comb begin
        op.fire  = cs & req & ~ack;
        op.write = ~rnw;
        op.sel   = rsel;
        op.data  = wdata;
    end

    assign hold_clear = op.fire & ~op.write & (op.sel == SEL_HOLD);

    always_comb begin
        rmux = '0;
        case (op.sel)
            SEL_DATA: rmux = mix_read(drv, dir, pins_sync);
            SEL_DIR:  rmux = dir;
            SEL_CTRL: rmux = {{(PORT_W-2){1'b0}}, ctrl.fall, ctrl.ien};
            SEL_STAT: rmux = {{(PORT_W-2){1'b0}}, overrun, ready};
            SEL_HOLD: rmux = hold;
            default:  rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            rdata   <= '0;
            drv     <= '0;
            dir     <= '0;
            ctrl    <= '0;
            stb_out <= 1'b0;
        end else begin
            ack     <= cs & req;
            stb_out <= op.fire & op.write & (op.sel == SEL_DATA);
            if (op.fire) begin
                if (op.write) begin
                    case (op.sel)
                        SEL_DATA: drv <= op.data;
                        SEL_DIR:  dir <= op.data;
                        SEL_CTRL: begin
                            ctrl.ien  <= op.data[0];
                            ctrl.fall <= op.data[1];
                        end
                        default: ;
                    endcase
                end else begin
                    rdata <= rmux;
                end
            end
        end
    end
endmodule

// File: rtl/bport.sv
module bport
    import bport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              req,
    input  logic              rnw,
    input  logic [SEL_W-1:0]  rsel,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] rdata,
    output logic              ack,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    input  logic              dev_stb_in,
    output logic              dev_stb_out,
    output logic              irq
);
    logic [PORT_W-1:0] pins_sync;
    logic              stb_sync;
    logic [PORT_W-1:0] hold;
    logic              ready, overrun, hold_clear;
    ctrl_t             ctrl;

    bport_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_pin_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pins_sync)
    );

    bport_sync #(.W(1), .STAGES(SYNC_N)) u_stb_sync (
        .clk(clk), .rst(rst), .d(dev_stb_in), .q(stb_sync)
    );

    bport_capture u_capture (
        .clk(clk), .rst(rst), .stb_sync(stb_sync), .fall_sel(ctrl.fall),
        .pins_sync(pins_sync), .clear(hold_clear),
        .hold(hold), .ready(ready), .overrun(overrun)
    );

    bport_regs u_regs (
        .clk(clk), .rst(rst), .cs(cs), .req(req), .rnw(rnw), .rsel(rsel),
        .wdata(wdata), .pins_sync(pins_sync), .hold(hold), .ready(ready),
        .overrun(overrun), .ack(ack), .rdata(rdata), .drv(pin_out),
        .dir(pin_oe), .ctrl(ctrl), .stb_out(dev_stb_out),
        .hold_clear(hold_clear)
    );

    assign irq = ctrl.ien & ready;
endmodule

// File: rtl/bport_chk.sv
module bport_chk
    import bport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              req,
    input logic              rnw,
    input logic [SEL_W-1:0]  rsel,
    input logic              ack,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe,
    input logic              dev_stb_out
);
    logic started;
    always_ff @(posedge clk) started <= rst ? 1'b1 : started;

    p_ack_drop_r2: assert property (@(posedge clk) disable iff (rst || !started)
        !req |=> !ack);

    p_stb_single_r6: assert property (@(posedge clk) disable iff (rst || !started)
        dev_stb_out |=> !dev_stb_out);

    p_stb_cause_r6: assert property (@(posedge clk) disable iff (rst || !started)
        dev_stb_out |-> $past(cs && req && !ack && !rnw && rsel == 3'd0));

    p_dir_hold_r3: assert property (@(posedge clk) disable iff (rst || !started)
        !(cs && req && !ack && !rnw && rsel == 3'd1) |=> $stable(pin_oe));

    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst || !started)
        !(cs && req && !ack && !rnw && rsel == 3'd0) |=> $stable(pin_out));
endmodule

bind bport bport_chk u_chk (
    .clk(clk), .rst(rst), .cs(cs), .req(req), .rnw(rnw), .rsel(rsel),
    .ack(ack), .pin_out(pin_out), .pin_oe(pin_oe), .dev_stb_out(dev_stb_out)
);

// File: tb/bport_tb.sv
module bport_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, req = 1'b0, rnw = 1'b1;
    logic [2:0] rsel = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic       dev_stb_in = 1'b0;
    logic       dev_stb_out, irq;

    int checks = 0;
    int fails  = 0;
    logic       stb_mid, stb_end, ack_mid, ack_end;
    logic [7:0] q;

    always #10 clk = ~clk;

    bport u_dut (
        .clk(clk), .rst(rst), .cs(cs), .req(req), .rnw(rnw), .rsel(rsel),
        .wdata(wdata), .rdata(rdata), .ack(ack), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .dev_stb_in(dev_stb_in),
        .dev_stb_out(dev_stb_out), .irq(irq)
    );

    function automatic logic [7:0] exp_mix(input logic [7:0] d, input logic [7:0] r,
                                           input logic [7:0] p);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) m[b] = r[b] ? d[b] : p[b];
        return m;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
        @(negedge clk);
        cs = 1'b1; req = 1'b1; rnw = ~w; rsel = a; wdata = d;
        @(negedge clk);
        rd = rdata; stb_mid = dev_stb_out; ack_mid = ack;
        cs = 1'b0; req = 1'b0;
        @(negedge clk);
        stb_end = dev_stb_out; ack_end = ack;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] dummy;
        xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        xfer(1'b0, a, 8'h00, v);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] mdrv, mdir, v;
        int cnt;
        mdrv = 8'h00; mdir = 8'h00;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 ack", ack, 0);
        check("R1 stb", dev_stb_out, 0);

        // R3 direction write/readback
        wr(3'd1, 8'hA5); mdir = 8'hA5;
        check("R2 ack mid", ack_mid, 1);
        check("R2 ack end", ack_end, 0);
        check("R3 pin_oe", pin_oe, 8'hA5);
        rd(3'd1, v);
        check("R3 readback", v, 8'hA5);

        // R5/R6 data write and strobe
        wr(3'd0, 8'h3C); mdrv = 8'h3C;
        check("R5 pin_out", pin_out, 8'h3C);
        check("R6 stb mid", stb_mid, 1);
        check("R6 stb end", stb_end, 0);

        // R5 cs low ignored
        @(negedge clk); cs = 0; req = 1; rnw = 0; rsel = 3'd0; wdata = 8'hFF;
        settle(2);
        check("R5 cs low pin_out", pin_out, 8'h3C);
        check("R2 cs low ack", ack, 0);
        req = 0; settle(1);

        // R2 held request: one access, one strobe
        cs = 1; req = 1; rnw = 0; rsel = 3'd0; wdata = 8'h81;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (dev_stb_out) cnt++;
            wdata = 8'h18;
        end
        cs = 0; req = 0;
        settle(2);
        check("R2 held single access", cnt, 1);
        check("R2 held value", pin_out, 8'h81);
        mdrv = 8'h81;

        // R4 random mixed reads
        for (int n = 0; n < 20; n++) begin
            mdir = 8'($urandom); mdrv = 8'($urandom);
            wr(3'd1, mdir); wr(3'd0, mdrv);
            pin_in = 8'($urandom);
            settle(3);
            rd(3'd0, v);
            check("R4 mixed read", v, exp_mix(mdrv, mdir, pin_in));
        end
        // corner patterns
        wr(3'd1, 8'h00); pin_in = 8'h5A; settle(3); rd(3'd0, v);
        check("R4 all inputs", v, 8'h5A);
        wr(3'd1, 8'hFF); rd(3'd0, v);
        check("R4 all outputs", v, mdrv);

        // R7 rising capture
        wr(3'd2, 8'h01);
        pin_in = 8'hC3;
        @(negedge clk); dev_stb_in = 1;
        settle(4);
        check("R8 irq set", irq, 1);
        rd(3'd3, v);
        check("R7 ready", v, 8'h01);
        pin_in = 8'h11;
        rd(3'd4, v);
        check("R7 hold", v, 8'hC3);
        check("R8 irq cleared", irq, 0);
        rd(3'd3, v);
        check("R8 status cleared", v, 8'h00);

        // falling edge inactive under rising polarity
        @(negedge clk); dev_stb_in = 0; settle(4);
        rd(3'd3, v);
        check("R7 falling ignored", v, 8'h00);

        // R7 falling polarity, R9 overrun
        wr(3'd2, 8'h02);
        rd(3'd2, v);
        check("R7 ctrl readback", v, 8'h02);
        pin_in = 8'h66; @(negedge clk); dev_stb_in = 1; settle(4);
        rd(3'd3, v);
        check("R7 rising ignored when falling", v, 8'h00);
        @(negedge clk); dev_stb_in = 0; settle(4);
        check("R8 irq disabled", irq, 0);
        pin_in = 8'h99; @(negedge clk); dev_stb_in = 1; settle(2);
        @(negedge clk); dev_stb_in = 0; settle(4);
        rd(3'd3, v);
        check("R9 overrun", v, 8'h03);
        rd(3'd4, v);
        check("R9 newer sample", v, 8'h99);
        rd(3'd3, v);
        check("R9 cleared", v, 8'h00);

        // R10 unused selects
        for (int s = 5; s < 8; s++) begin
            wr(3'(s), 8'hFF);
            rd(3'(s), v);
            check("R10 unused reads zero", v, 8'h00);
        end
        wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
        rd(3'd3, v);
        check("R10 status write ignored", v, 8'h00);
        rd(3'd4, v);
        check("R10 hold write ignored", v, 8'h99);
        check("R10 outputs untouched", {pin_oe, pin_out}, {8'hFF, mdrv});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule